// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between a simple request/response bus and a single-port synchronous SRAM. Ordinary SRAM addresses pass straight through with byte-lane enables. A second, larger address window maps every SRAM bit onto its own word-aligned alias address. A read through that window returns the chosen bit alone. A write through it changes that one bit of the target SRAM word and leaves every other bit as it was.

An alias write becomes a read of the target word followed by a write of the merged word. Between the two steps the unit holds the bus in a wait state, so no other access can come between the read and the write. Each bit number addresses its own word in the alias window: the alias offset divided by 32 gives the byte offset, and alias bits [4:2] give the bit within that byte.

Top module: `bitband_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ready_o is 1, rvalid_o is 0 and mem_en_o is 0 when no request is presented.
- R2: An address inside [0x2000_0000, 0x2000_0000 + MEM_BYTES) is a direct access. The SRAM word index is (addr − 0x2000_0000) >> 2. Bit n of be_i enables data bits [8n+7:8n] of a write. A read returns the SRAM word unchanged.
- R3: An address inside [0x2200_0000, 0x2200_0000 + 32·MEM_BYTES) is an alias access. The byte offset is (addr − 0x2200_0000) >> 5 and the bit number is addr[4:2]; addr[1:0] are ignored. The target is bit 8·(byte offset mod 4) + bit number of word (byte offset >> 2). For example, alias 0x2200_401C is bit 7 of byte 0x2000_0200.
- R4: An alias read returns the target bit in rdata_o[0], with rdata_o[31:1] equal to zero.
- R5: An alias write stores wdata_i[0] into the target bit and leaves the other 31 bits of the word unchanged. wdata_i[31:1] have no effect.
- R6: After an alias write is accepted, ready_o is 0 for exactly one cycle. In that cycle the unit writes the merged data back to the same SRAM word, and it makes no other SRAM access between the read and that write.
- R7: An address outside both windows makes no SRAM access. A read returns 0 and a write has no effect on any SRAM word.
- R8: rvalid_o is 1 exactly in the cycle after a read is accepted and is 0 at all other times. rdata_o is valid while rvalid_o is 1.
- R9: A request is accepted on a clock edge where req_i and ready_o are both 1. A request held while ready_o is 0 waits and is served once ready_o returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| be_i | input | 4 | Byte-lane enables for direct writes |
| wdata_i | input | 32 | Write data; for an alias write only bit 0 is used |
| ready_o | output | 1 | Unit can accept a request |
| rvalid_o | output | 1 | Read response valid |
| rdata_o | output | 32 | Read response data |
| mem_en_o | output | 1 | SRAM access enable |
| mem_we_o | output | 1 | SRAM write enable |
| mem_addr_o | output | WAW | SRAM word index |
| mem_be_o | output | 4 | SRAM byte-lane write enables |
| mem_wdata_o | output | 32 | SRAM write data |
| mem_rdata_i | input | 32 | SRAM read data, valid one cycle after a read |

## Verification
The assertions assume that the SRAM returns read data in the cycle after it is enabled without a write, and that no other agent writes the SRAM. The single-bit check on the write-back depends on both. The assertions also assume that req_i and the request fields stay stable during a wait state. The bench holds a behavioural one-cycle SRAM that only this unit drives. It changes request fields only at falling edges, and it keeps a waiting request unchanged until the edge that accepts it.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_DIRECT = 2'd1,
    RGN_ALIAS  = 2'd2
  } region_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RMW  = 1'b1
  } state_e;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          MEM_BYTES  = 16384,
  localparam int         WAW        = $clog2(MEM_BYTES / 4)
) (
  input  logic [31:0]    addr_i,
  output region_e        region_o,
  output logic [WAW-1:0] word_o,
  output logic [4:0]     bitpos_o
);
  localparam logic [31:0] D_SPAN = 32'(MEM_BYTES);
  localparam logic [31:0] A_SPAN = 32'(MEM_BYTES) << 5;

  logic [31:0] doff, aoff;

  assign doff = addr_i - SRAM_BASE;
  assign aoff = addr_i - ALIAS_BASE;

  always_comb begin
    region_o = RGN_NONE;
    word_o   = '0;
    bitpos_o = '0;
    if (doff < D_SPAN) begin
      region_o = RGN_DIRECT;
      word_o   = doff[WAW+1:2];
    end else if (aoff < A_SPAN) begin
      region_o = RGN_ALIAS;
      // byte offset = aoff >> 5, so word = aoff >> 7, lane = aoff[6:5], bit = aoff[4:2]
      word_o   = aoff[WAW+6:7];
      bitpos_o = aoff[6:2];
    end
  end
endmodule

// File: rtl/bb_bitops.sv
module bb_bitops #(
  parameter int DW = 32,
  localparam int PW = $clog2(DW),
  localparam int NL = DW / 8
) (
  input  logic [DW-1:0] word_i,
  input  logic [PW-1:0] pos_i,
  input  logic          val_i,
  output logic          bit_o,
  output logic [DW-1:0] merged_o,
  output logic [NL-1:0] lane_o
);
  assign bit_o  = word_i[pos_i];
  assign lane_o = NL'(1) << pos_i[PW-1:3];

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign merged_o[i] = (pos_i == PW'(i)) ? val_i : word_i[i];
  end
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
#(
  parameter int WAW = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [3:0]     be_i,
  input  logic [31:0]    wdata_i,
  input  region_e        region_i,
  input  logic [WAW-1:0] word_i,
  input  logic [4:0]     bitpos_i,
  input  logic [31:0]    merged_i,
  input  logic [3:0]     lane_i,
  output logic           ready_o,
  output logic           rvalid_o,
  output region_e        rsel_o,
  output logic [4:0]     bitpos_o,
  output logic           bitval_o,
  output logic           mem_en_o,
  output logic           mem_we_o,
  output logic [WAW-1:0] mem_addr_o,
  output logic [3:0]     mem_be_o,
  output logic [31:0]    mem_wdata_o
);
  state_e         state_q;
  logic           rvalid_q, bitval_q, accept;
  region_e        rsel_q;
  logic [WAW-1:0] word_q;
  logic [4:0]     bitpos_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept   = req_i && ready_o;
  assign rvalid_o = rvalid_q;
  assign rsel_o   = rsel_q;
  assign bitpos_o = bitpos_q;
  assign bitval_o = bitval_q;

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    if (state_q == ST_RMW) begin
      mem_en_o    = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = word_q;
      mem_be_o    = lane_i;
      mem_wdata_o = merged_i;
    end else if (accept) begin
      unique case (region_i)
        RGN_DIRECT: begin
          mem_en_o    = 1'b1;
          mem_we_o    = we_i;
          mem_addr_o  = word_i;
          mem_be_o    = be_i;
          mem_wdata_o = wdata_i;
        end
        RGN_ALIAS: begin
          mem_en_o   = 1'b1;
          mem_addr_o = word_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rvalid_q <= 1'b0;
      rsel_q   <= RGN_NONE;
      word_q   <= '0;
      bitpos_q <= '0;
      bitval_q <= 1'b0;
    end else if (accept) begin
      rvalid_q <= !we_i;
      rsel_q   <= region_i;
      word_q   <= word_i;
      bitpos_q <= bitpos_i;
      bitval_q <= wdata_i[0];
      state_q  <= (we_i && region_i == RGN_ALIAS) ? ST_RMW : ST_IDLE;
    end else begin
      rvalid_q <= 1'b0;
      state_q  <= ST_IDLE;
    end
  end
endmodule

// File: rtl/bitband_unit.sv
module bitband_unit
  import bb_pkg::*;
#(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          MEM_BYTES  = 16384,
  localparam int         WAW        = $clog2(MEM_BYTES / 4)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [31:0]    addr_i,
  input  logic [3:0]     be_i,
  input  logic [31:0]    wdata_i,
  output logic           ready_o,
  output logic           rvalid_o,
  output logic [31:0]    rdata_o,
  output logic           mem_en_o,
  output logic           mem_we_o,
  output logic [WAW-1:0] mem_addr_o,
  output logic [3:0]     mem_be_o,
  output logic [31:0]    mem_wdata_o,
  input  logic [31:0]    mem_rdata_i
);
  region_e        rgn, rsel;
  logic [WAW-1:0] dec_word;
  logic [4:0]     dec_bitpos, bitpos_q;
  logic           bitval_q, sel_bit;
  logic [31:0]    merged;
  logic [3:0]     lane;

  bb_decode #(
    .SRAM_BASE (SRAM_BASE),
    .ALIAS_BASE(ALIAS_BASE),
    .MEM_BYTES (MEM_BYTES)
  ) u_decode (
    .addr_i  (addr_i),
    .region_o(rgn),
    .word_o  (dec_word),
    .bitpos_o(dec_bitpos)
  );

  bb_bitops #(.DW(32)) u_bitops (
    .word_i  (mem_rdata_i),
    .pos_i   (bitpos_q),
    .val_i   (bitval_q),
    .bit_o   (sel_bit),
    .merged_o(merged),
    .lane_o  (lane)
  );

  bb_ctrl #(.WAW(WAW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .be_i       (be_i),
    .wdata_i    (wdata_i),
    .region_i   (rgn),
    .word_i     (dec_word),
    .bitpos_i   (dec_bitpos),
    .merged_i   (merged),
    .lane_i     (lane),
    .ready_o    (ready_o),
    .rvalid_o   (rvalid_o),
    .rsel_o     (rsel),
    .bitpos_o   (bitpos_q),
    .bitval_o   (bitval_q),
    .mem_en_o   (mem_en_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_be_o   (mem_be_o),
    .mem_wdata_o(mem_wdata_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rvalid_o) begin
      unique case (rsel)
        RGN_DIRECT: rdata_o = mem_rdata_i;
        RGN_ALIAS:  rdata_o = {31'd0, sel_bit};
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bitband_unit_chk.sv
module bitband_unit_chk
  import bb_pkg::*;
#(
  parameter int WAW = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic           ready_o,
  input logic           rvalid_o,
  input logic [31:1]    rdata_hi,
  input logic           mem_en_o,
  input logic           mem_we_o,
  input logic [WAW-1:0] mem_addr_o,
  input logic [31:0]    mem_wdata_o,
  input logic [31:0]    mem_rdata_i,
  input region_e        rgn
);
  AST_ALIAS_RD_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !we_i && rgn == RGN_ALIAS) |=> (rvalid_o && rdata_hi == 31'd0)); // R4

  AST_RMW_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && we_i && rgn == RGN_ALIAS) |=> (!ready_o && mem_en_o && mem_we_o)); // R6

  AST_RMW_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> ($countones(mem_wdata_o ^ mem_rdata_i) <= 1)); // R5

  AST_RMW_SAME_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (mem_addr_o == $past(mem_addr_o))); // R6

  AST_RMW_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o); // R6

  AST_OUTSIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && rgn == RGN_NONE) |-> !mem_en_o); // R7

  AST_RVALID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && ready_o && !we_i)); // R8

  AST_WE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o); // R2
endmodule

bind bitband_unit bitband_unit_chk #(.WAW(WAW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .ready_o    (ready_o),
  .rvalid_o   (rvalid_o),
  .rdata_hi   (rdata_o[31:1]),
  .mem_en_o   (mem_en_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdata_i(mem_rdata_i),
  .rgn        (rgn)
);

// File: tb/bitband_unit_bench.sv
`timescale 1ns/1ps
module bitband_unit_bench;
  localparam int MEM_BYTES = 16384;
  localparam int WAW       = $clog2(MEM_BYTES / 4);
  localparam int NW        = MEM_BYTES / 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           req_i = 1'b0, we_i = 1'b0;
  logic [31:0]    addr_i = '0, wdata_i = '0;
  logic [3:0]     be_i = '0;
  logic           ready_o, rvalid_o, mem_en_o, mem_we_o;
  logic [31:0]    rdata_o, mem_wdata_o;
  logic [31:0]    mem_rdata_i;
  logic [WAW-1:0] mem_addr_o;
  logic [3:0]     mem_be_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bitband_unit #(.MEM_BYTES(MEM_BYTES)) u_bitband_unit (.*);

  logic [31:0] mem [NW];
  initial for (int i = 0; i < NW; i++) mem[i] = '0;
  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o][8*b +: 8] <= mem_wdata_o[8*b +: 8];
      end else begin
        mem_rdata_i <= mem[mem_addr_o];
      end
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one transfer; returns values seen at the falling edge after acceptance
  task automatic xfer(input logic we, input logic [3:0] be, input logic [31:0] addr,
                      input logic [31:0] wd, output logic rv, output logic [31:0] rd,
                      output logic rdy);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; be_i = be; addr_i = addr; wdata_i = wd;
    while (!ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    rv = rvalid_o; rd = rdata_o; rdy = ready_o;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // {req(4), we(1), be(4), addr(32), wdata(32), expected(32)}
  localparam int NV = 24;
  localparam logic [104:0] VEC [NV] = '{
    {4'd2, 1'b1, 4'hF, 32'h2000_0200, 32'h0000_0000, 32'h0},          // R2
    {4'd5, 1'b1, 4'hF, 32'h2200_401C, 32'h0000_0001, 32'h0},          // R5 bit7 of 0x200
    {4'd5, 1'b0, 4'hF, 32'h2000_0200, 32'h0,         32'h0000_0080},  // R5
    {4'd4, 1'b0, 4'hF, 32'h2200_401C, 32'h0,         32'h0000_0001},  // R4
    {4'd4, 1'b0, 4'hF, 32'h2200_4018, 32'h0,         32'h0000_0000},  // R4
    {4'd3, 1'b0, 4'hF, 32'h2200_401F, 32'h0,         32'h0000_0001},  // R3 low bits ignored
    {4'd2, 1'b1, 4'hF, 32'h2000_0204, 32'hFFFF_FFFF, 32'h0},          // R2
    {4'd5, 1'b1, 4'hF, 32'h2200_40AC, 32'hFFFF_FFFE, 32'h0},          // R5 bit0=0 only
    {4'd5, 1'b0, 4'hF, 32'h2000_0204, 32'h0,         32'hFFFF_F7FF},  // R5
    {4'd3, 1'b0, 4'hF, 32'h2200_40AC, 32'h0,         32'h0000_0000},  // R3
    {4'd4, 1'b0, 4'hF, 32'h2200_40A8, 32'h0,         32'h0000_0001},  // R4
    {4'd2, 1'b1, 4'hF, 32'h2000_0208, 32'h1122_3344, 32'h0},          // R2
    {4'd2, 1'b1, 4'h2, 32'h2000_0208, 32'h0000_AB00, 32'h0},          // R2 lane 1
    {4'd2, 1'b0, 4'hF, 32'h2000_0208, 32'h0,         32'h1122_AB44},  // R2
    {4'd3, 1'b1, 4'hF, 32'h2207_FFFC, 32'h0000_0001, 32'h0},          // R3 last bit
    {4'd3, 1'b0, 4'hF, 32'h2000_3FFC, 32'h0,         32'h8000_0000},  // R3
    {4'd7, 1'b1, 4'hF, 32'h2000_4000, 32'hDEAD_BEEF, 32'h0},          // R7
    {4'd7, 1'b0, 4'hF, 32'h2000_0000, 32'h0,         32'h0000_0000},  // R7 no wrap
    {4'd7, 1'b1, 4'hF, 32'h2208_0000, 32'h0000_0001, 32'h0},          // R7
    {4'd7, 1'b0, 4'hF, 32'h2000_0000, 32'h0,         32'h0000_0000},  // R7 no wrap
    {4'd7, 1'b0, 4'hF, 32'h2000_4000, 32'h0,         32'h0000_0000},  // R7
    {4'd7, 1'b0, 4'hF, 32'h21FF_FFFC, 32'h0,         32'h0000_0000},  // R7
    {4'd5, 1'b1, 4'hF, 32'h2200_0000, 32'h0000_0001, 32'h0},          // R5
    {4'd3, 1'b0, 4'hF, 32'h2000_0000, 32'h0,         32'h0000_0001}   // R3
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    logic rv, rdy;
    logic [31:0] rd;

    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(ready_o && !rvalid_o && !mem_en_o, "R1", {29'd0, ready_o, rvalid_o, mem_en_o}, 32'h4);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ready_o && !rvalid_o && !mem_en_o, "R1", {29'd0, ready_o, rvalid_o, mem_en_o}, 32'h4);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] rq;
      logic [104:0] e;
      string tag;
      e = VEC[v];
      rq = e[104:101];
      tag = $sformatf("R%0d", rq);
      xfer(e[100], e[99:96], e[95:64], e[63:32], rv, rd, rdy);
      if (e[100]) begin
        check(!rv, "R8", {31'd0, rv}, 32'd0);
        if (e[95:64] >= 32'h2200_0000 && e[95:64] < 32'h2208_0000) begin
          check(!rdy, "R6", {31'd0, rdy}, 32'd0);
          @(negedge clk_i);
          check(ready_o, "R6", {31'd0, ready_o}, 32'd1);
        end
      end else begin
        check(rv && rd == e[31:0], tag, rd, e[31:0]);
      end
    end

    // R8: rvalid lasts one cycle only
    xfer(1'b0, 4'hF, 32'h2000_0208, 32'h0, rv, rd, rdy);
    @(negedge clk_i);
    check(!rvalid_o, "R8", {31'd0, rvalid_o}, 32'd0);

    // R9 / R6: request held during the wait state is served afterwards
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; be_i = 4'hF; addr_i = 32'h2200_0004; wdata_i = 32'h1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 32'h2000_0000;
    check(!ready_o && mem_en_o && mem_we_o && !rvalid_o, "R6",
          {28'd0, ready_o, mem_en_o, mem_we_o, rvalid_o}, 32'h6);
    @(posedge clk_i);
    @(negedge clk_i);
    check(ready_o && !rvalid_o, "R9", {30'd0, ready_o, rvalid_o}, 32'h2);
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    check(rvalid_o && rdata_o == 32'h3, "R9", rdata_o, 32'h3);

    // R9: without req_i nothing is accepted
    @(negedge clk_i);
    check(!mem_en_o && !rvalid_o, "R9", {30'd0, mem_en_o, rvalid_o}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule